// File: doc/BRIEF.md
# DDR SDRAM Command Sequencing Monitor

This block is a passive observer placed on the command bus of a four-bank DDR SDRAM. It samples the clock enable, the chip select and the three strobe lines, the two bank-select bits and the auto-precharge address bit on every rising clock edge. It decodes each command, keeps its own view of which banks hold an open row, and follows the end of each burst and the short quiet period after a mode-register write. It drives nothing onto the memory bus.

Whenever a command breaks a sequencing rule, the monitor raises a one-cycle violation pulse and loads a reason code. The reason code stays the same until the next violation. A command that is flagged is treated as rejected, so it does not change the monitor's view of the banks. The burst length and the precharge recovery time are parameters. Data, strobe timing, refresh intervals and electrical parameters are not modelled.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: A synchronous active-high reset clears the violation flag and sets the reason code to 0. It also marks every bank as precharged and clears all burst and hold-off tracking.
- R2: A mode register write while any bank is open, or still recovering from an auto precharge, is flagged with reason 1.
- R3: A refresh command while any bank is open or recovering is flagged with reason 3. This holds for auto refresh, where CKE stays high, and for self-refresh entry, where CKE falls in the command cycle.
- R4: A read or a write to a bank that is not open is flagged with reason 4.
- R5: An activate to a bank that is already open is flagged with reason 5.
- R6: A precharge with the auto-precharge bit high closes all four banks, whatever the bank-select bits are. With that bit low, it closes only the selected bank.
- R7: Any command other than NOP or deselect in the cycle right after an accepted mode register write is flagged with reason 2. A command two or more cycles after that write is judged by the other rules only.
- R8: After an accepted write with the auto-precharge bit high, any read or write in the next BURST_LEN/2-1 cycles is flagged with reason 6.
- R9: A read or write with auto precharge closes its bank. Once the burst has ended, a read or write to another open bank is accepted. An activate to the closed bank is flagged with reason 7 until BURST_LEN/2+T_RP cycles after the read or write, and is accepted from that cycle on.
- R10: A burst stop is accepted at any time and ends the current burst. A read or write in the next cycle is therefore not flagged for the auto-precharge write lockout.
- R11: Commands decode from {CS#,RAS#,CAS#,WE#}: 1xxx is deselect, 0111 NOP, 0011 activate, 0101 read, 0100 write, 0110 burst stop, 0010 precharge, 0001 refresh, 0000 mode register write. A deselect or NOP is never flagged and changes no bank state, whatever the other lines carry.
- R12: A command sampled in a cycle whose previous sampled CKE was low is ignored.
- R13: The violation flag rises one cycle after the offending command and lasts exactly one cycle. A flagged command changes no bank state. The reason code is held through legal commands until the next violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable as seen on the bus |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Auto-precharge / all-banks address bit |
| violation | output | 1 | One-cycle pulse when a command breaks a rule |
| reason | output | 4 | Code of the most recent violation |

## Verification
The bench opens and closes banks in several orders: single-bank precharge, all-bank precharge with unrelated bank bits, and closing by auto precharge. A precharge that closes too much or too little then shows up as a wrong verdict on the next read or activate. Mode register and refresh commands are issued with one bank open and with all banks idle, so a reason code 1 or 3 can be told apart from a missing precondition check. The hold-off, the auto-precharge write lockout and the recovery window are each probed in the last cycle that must be flagged and in the first cycle that must be accepted. This exposes off-by-one errors in the counters. Deselect patterns that mimic an activate, and commands that follow a low CKE, separate decoding that ignores these cycles from decoding that acts on them.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

  localparam int BANK_BITS = 2;
  localparam int NUM_BANKS = 1 << BANK_BITS;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_BST, CMD_PRE, CMD_REF, CMD_MRS
  } cmdE;

  typedef enum logic [3:0] {
    RSN_NONE      = 4'd0,
    RSN_MRS_BUSY  = 4'd1,
    RSN_MRS_HOLD  = 4'd2,
    RSN_REF_BUSY  = 4'd3,
    RSN_RW_CLOSED = 4'd4,
    RSN_ACT_OPEN  = 4'd5,
    RSN_AP_LOCK   = 4'd6,
    RSN_ACT_TRP   = 4'd7
  } reasonE;

  typedef struct packed {
    logic                 flag;
    reasonE               code;
    logic                 actEn;
    logic                 preOne;
    logic                 preAll;
    logic                 burstStart;
    logic                 burstApWr;
    logic                 apClose;
    logic                 burstStop;
    logic                 mrsStart;
    logic [BANK_BITS-1:0] bank;
  } strobeS;

endpackage

// File: rtl/ddr_mon_ctrl.sv
module ddr_mon_ctrl
  import ddr_mon_pkg::*;
(
  input  logic                 prevCke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_BITS-1:0] ba,
  input  logic                 a10,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [NUM_BANKS-1:0] bankRecov,
  input  logic                 lockActive,
  input  logic                 holdActive,
  output strobeS               stb
);

  cmdE  cmd;
  logic allIdle;

  // Command decode; a cycle after low CKE decodes as NOP
  always_comb begin
    cmd = CMD_NOP;
    if (prevCke && !csN) begin
      unique case ({rasN, casN, weN})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_BST;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        default: cmd = CMD_MRS;
      endcase
    end
  end

  assign allIdle = ~|bankOpen && ~|bankRecov;

  // Rule checks; a rejected command raises no state strobe
  always_comb begin
    stb      = '0;
    stb.code = RSN_NONE;
    stb.bank = ba;
    if (cmd != CMD_NOP && holdActive) begin
      stb.flag = 1'b1;
      stb.code = RSN_MRS_HOLD;
    end else begin
      unique case (cmd)
        CMD_MRS: begin
          if (!allIdle) begin
            stb.flag = 1'b1;
            stb.code = RSN_MRS_BUSY;
          end else begin
            stb.mrsStart = 1'b1;
          end
        end
        CMD_REF: begin
          if (!allIdle) begin
            stb.flag = 1'b1;
            stb.code = RSN_REF_BUSY;
          end
        end
        CMD_ACT: begin
          if (bankOpen[ba]) begin
            stb.flag = 1'b1;
            stb.code = RSN_ACT_OPEN;
          end else if (bankRecov[ba]) begin
            stb.flag = 1'b1;
            stb.code = RSN_ACT_TRP;
          end else begin
            stb.actEn = 1'b1;
          end
        end
        CMD_RD, CMD_WR: begin
          if (lockActive) begin
            stb.flag = 1'b1;
            stb.code = RSN_AP_LOCK;
          end else if (!bankOpen[ba]) begin
            stb.flag = 1'b1;
            stb.code = RSN_RW_CLOSED;
          end else begin
            stb.burstStart = 1'b1;
            stb.burstApWr  = (cmd == CMD_WR) && a10;
            stb.apClose    = a10;
          end
        end
        CMD_BST: stb.burstStop = 1'b1;
        CMD_PRE: begin
          stb.preAll = a10;
          stb.preOne = !a10;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ddr_mon_state.sv
module ddr_mon_state
  import ddr_mon_pkg::*;
#(
  parameter int BURST_LEN = 8,
  parameter int T_RP      = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cke,
  input  strobeS               stb,
  output logic                 prevCke,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [NUM_BANKS-1:0] bankRecov,
  output logic                 lockActive,
  output logic                 holdActive,
  output logic                 violation,
  output logic [3:0]           reason
);

  localparam int BURST_CYC = BURST_LEN / 2;
  localparam int BURST_W   = $clog2(BURST_CYC + 1);
  localparam int REC_LOAD  = BURST_CYC + T_RP - 1;
  localparam int REC_W     = $clog2(REC_LOAD + 1);

  logic [BURST_W-1:0] burstCnt;
  logic               apWrQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevCke    <= 1'b1;
      holdActive <= 1'b0;
      violation  <= 1'b0;
      reason     <= 4'd0;
    end else begin
      prevCke    <= cke;
      holdActive <= stb.mrsStart;
      violation  <= stb.flag;
      if (stb.flag) reason <= stb.code;
    end
  end

  // Burst window and auto-precharge write lockout
  always_ff @(posedge clk) begin
    if (rst) begin
      burstCnt <= '0;
      apWrQ    <= 1'b0;
    end else if (stb.burstStart) begin
      burstCnt <= BURST_W'(BURST_CYC - 1);
      apWrQ    <= stb.burstApWr;
    end else if (stb.burstStop) begin
      burstCnt <= '0;
      apWrQ    <= 1'b0;
    end else if (burstCnt != '0) begin
      burstCnt <= burstCnt - BURST_W'(1);
    end
  end

  assign lockActive = apWrQ && (burstCnt != '0);

  // Per-bank row state and recovery counters
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic             openQ;
    logic [REC_W-1:0] recCnt;
    logic             hit;

    assign hit = (stb.bank == BANK_BITS'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        openQ <= 1'b0;
      end else if (stb.actEn && hit) begin
        openQ <= 1'b1;
      end else if (stb.preAll || ((stb.preOne || stb.apClose) && hit)) begin
        openQ <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        recCnt <= '0;
      end else if (stb.apClose && hit) begin
        recCnt <= REC_W'(REC_LOAD);
      end else if (recCnt != '0) begin
        recCnt <= recCnt - REC_W'(1);
      end
    end

    assign bankOpen[i]  = openQ;
    assign bankRecov[i] = (recCnt != '0);
  end

endmodule

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor
  import ddr_mon_pkg::*;
#(
  parameter int BURST_LEN = 8,
  parameter int T_RP      = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic       csN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  input  logic [1:0] ba,
  input  logic       a10,
  output logic       violation,
  output logic [3:0] reason
);

  strobeS               stb;
  logic                 prevCke;
  logic [NUM_BANKS-1:0] bankOpen;
  logic [NUM_BANKS-1:0] bankRecov;
  logic                 lockActive;
  logic                 holdActive;

  ddr_mon_ctrl u_ctrl (
    .prevCke    (prevCke),
    .csN        (csN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .ba         (ba),
    .a10        (a10),
    .bankOpen   (bankOpen),
    .bankRecov  (bankRecov),
    .lockActive (lockActive),
    .holdActive (holdActive),
    .stb        (stb)
  );

  ddr_mon_state #(
    .BURST_LEN (BURST_LEN),
    .T_RP      (T_RP)
  ) u_state (
    .clk        (clk),
    .rst        (rst),
    .cke        (cke),
    .stb        (stb),
    .prevCke    (prevCke),
    .bankOpen   (bankOpen),
    .bankRecov  (bankRecov),
    .lockActive (lockActive),
    .holdActive (holdActive),
    .violation  (violation),
    .reason     (reason)
  );

endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic       csN,
  input logic       rasN,
  input logic       casN,
  input logic       weN,
  input logic [1:0] ba,
  input logic       a10,
  input logic       violation,
  input logic [3:0] reason
);

  logic [1:0] aliveCnt;
  logic       pastCke;
  logic       valid;
  logic [3:0] code;
  logic       isAct, isRw, isPre, isMrs, isBusy;

  always_ff @(posedge clk) begin
    if (rst) begin
      aliveCnt <= 2'd0;
      pastCke  <= 1'b1;
    end else begin
      if (aliveCnt != 2'd3) aliveCnt <= aliveCnt + 2'd1;
      pastCke <= cke;
    end
  end

  assign code   = {csN, rasN, casN, weN};
  assign valid  = (aliveCnt == 2'd3) && pastCke && cke;
  assign isAct  = (code == 4'b0011);
  assign isRw   = (code == 4'b0101) || (code == 4'b0100);
  assign isPre  = (code == 4'b0010);
  assign isMrs  = (code == 4'b0000);
  assign isBusy = !csN && !(rasN && casN && weN);

  // R1: outputs cleared right after a reset edge
  always @(posedge clk) begin
    if (!rst && aliveCnt == 2'd0) begin
      p_reset_r1: assert (!violation && reason == 4'd0);
    end
  end

  // R13: reason holds when no violation is reported
  p_reason_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (aliveCnt != 2'd0 && !violation) |-> $stable(reason));

  // R11: deselect never produces a violation
  p_deselect_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (valid && csN) |=> !violation);

  // R7: command right after an accepted mode register write
  p_mrs_gap_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(valid && isMrs) && !violation && valid && isBusy)
      |=> (violation && reason == 4'd2));

  // R5: second activate to the same bank
  p_act_twice_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(valid && isAct) && !violation && valid && isAct && ba == $past(ba))
      |=> (violation && reason == 4'd5));

  // R6: read or write right after an accepted all-bank precharge
  p_rw_after_preall_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(valid && isPre && a10) && !violation && valid && isRw)
      |=> violation);

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk u_chk (.*);

// File: tb/ddr_cmd_monitor_tb.sv
`timescale 1ns/1ps
module ddr_cmd_monitor_tb;

  localparam logic [3:0] C_DES = 4'b1011;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_BST = 4'b0110;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke = 1'b1;
  logic       csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] ba = 2'd0;
  logic       a10 = 1'b0;
  logic       violation;
  logic [3:0] reason;

  logic       obsV;
  logic [3:0] obsR;
  int         nChecks = 0;
  int         nFail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  ddr_cmd_monitor #(.BURST_LEN(8), .T_RP(3)) u_dut (
    .clk(clk), .rst(rst), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .a10(a10), .violation(violation), .reason(reason)
  );

  task automatic setBus(input logic [3:0] c, input logic [1:0] b,
                        input logic ap, input logic ck);
    {csN, rasN, casN, weN} = c;
    ba  = b;
    a10 = ap;
    cke = ck;
  endtask

  // One command for one cycle, result sampled after the edge
  task automatic issue(input logic [3:0] c, input logic [1:0] b,
                       input logic ap, input logic ck);
    @(negedge clk);
    setBus(c, b, ap, ck);
    @(posedge clk);
    #1;
    obsV = violation;
    obsR = reason;
    setBus(C_NOP, 2'd0, 1'b0, 1'b1);
  endtask

  task automatic chk(input string tag, input logic ev, input logic [3:0] er);
    nChecks++;
    if (obsV !== ev || obsR !== er) begin
      nFail++;
      $display("FAIL %s: violation=%0b reason=%0d expected violation=%0b reason=%0d",
               tag, obsV, obsR, ev, er);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    setBus(C_NOP, 2'd0, 1'b0, 1'b1);
    repeat (2) @(posedge clk);
    #1;
    obsV = violation;
    obsR = reason;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    issue(C_RD, 2'd1, 1'b0, 1'b1);
    chk("R4 read before reset test", 1'b1, 4'd4);
    doReset();
    chk("R1 reset clears outputs", 1'b0, 4'd0);
    issue(C_ACT, 2'd0, 1'b0, 1'b1);
    chk("R1 bank precharged after reset", 1'b0, 4'd0);
  endtask

  task automatic testBankRules();
    doReset();
    issue(C_ACT, 2'd0, 1'b0, 1'b1);
    chk("R5 first activate", 1'b0, 4'd0);
    issue(C_RD, 2'd0, 1'b0, 1'b1);
    chk("R4 read open bank", 1'b0, 4'd0);
    issue(C_ACT, 2'd0, 1'b0, 1'b1);
    chk("R5 activate open bank", 1'b1, 4'd5);
    issue(C_WR, 2'd2, 1'b0, 1'b1);
    chk("R4 write closed bank", 1'b1, 4'd4);
    issue(C_ACT, 2'd2, 1'b0, 1'b1);
    chk("R13 reason held after legal command", 1'b0, 4'd4);
  endtask

  task automatic testPrecharge();
    doReset();
    issue(C_ACT, 2'd0, 1'b0, 1'b1);
    issue(C_ACT, 2'd1, 1'b0, 1'b1);
    issue(C_PRE, 2'd0, 1'b0, 1'b1);
    chk("R6 single precharge accepted", 1'b0, 4'd0);
    issue(C_RD, 2'd1, 1'b0, 1'b1);
    chk("R6 other bank stays open", 1'b0, 4'd0);
    issue(C_RD, 2'd0, 1'b0, 1'b1);
    chk("R6 selected bank closed", 1'b1, 4'd4);
    issue(C_PRE, 2'd3, 1'b1, 1'b1);
    issue(C_RD, 2'd1, 1'b0, 1'b1);
    chk("R6 all-bank precharge ignores bank bits", 1'b1, 4'd4);
  endtask

  task automatic testIdleRules();
    doReset();
    issue(C_ACT, 2'd2, 1'b0, 1'b1);
    issue(C_MRS, 2'd0, 1'b0, 1'b1);
    chk("R2 mode write with bank open", 1'b1, 4'd1);
    issue(C_REF, 2'd0, 1'b0, 1'b1);
    chk("R3 auto refresh with bank open", 1'b1, 4'd3);
    issue(C_PRE, 2'd2, 1'b0, 1'b1);
    chk("R13 legal precharge keeps reason", 1'b0, 4'd3);
    issue(C_ACT, 2'd1, 1'b0, 1'b1);
    issue(C_REF, 2'd0, 1'b0, 1'b0);
    chk("R3 self refresh entry with bank open", 1'b1, 4'd3);
    doReset();
    issue(C_REF, 2'd0, 1'b0, 1'b1);
    chk("R3 refresh when idle", 1'b0, 4'd0);
  endtask

  task automatic testMrsGap();
    doReset();
    issue(C_MRS, 2'd0, 1'b0, 1'b1);
    chk("R2 mode write when idle", 1'b0, 4'd0);
    issue(C_ACT, 2'd0, 1'b0, 1'b1);
    chk("R7 command one cycle after mode write", 1'b1, 4'd2);
    issue(C_ACT, 2'd0, 1'b0, 1'b1);
    chk("R7 R13 command two cycles after, bank untouched", 1'b0, 4'd2);
    doReset();
    issue(C_MRS, 2'd0, 1'b0, 1'b1);
    issue(C_DES, 2'd0, 1'b0, 1'b1);
    chk("R11 deselect during hold-off", 1'b0, 4'd0);
    issue(C_ACT, 2'd1, 1'b0, 1'b1);
    chk("R7 activate after deselect gap", 1'b0, 4'd0);
  endtask

  task automatic testAutoPrecharge();
    doReset();
    issue(C_ACT, 2'd0, 1'b0, 1'b1);
    issue(C_ACT, 2'd1, 1'b0, 1'b1);
    issue(C_WR, 2'd0, 1'b1, 1'b1);   // j=0
    chk("R8 write with auto precharge", 1'b0, 4'd0);
    issue(C_RD, 2'd1, 1'b0, 1'b1);   // j=1
    chk("R8 read during auto-precharge write", 1'b1, 4'd6);
    issue(C_NOP, 2'd0, 1'b0, 1'b1);  // j=2
    issue(C_WR, 2'd1, 1'b0, 1'b1);   // j=3
    chk("R8 write in last locked cycle", 1'b1, 4'd6);
    issue(C_RD, 2'd1, 1'b0, 1'b1);   // j=4
    chk("R9 other bank after burst end", 1'b0, 4'd6);
    issue(C_RD, 2'd0, 1'b0, 1'b1);   // j=5
    chk("R9 auto-precharged bank closed", 1'b1, 4'd4);
    issue(C_ACT, 2'd0, 1'b0, 1'b1);  // j=6
    chk("R9 activate inside recovery", 1'b1, 4'd7);
    issue(C_ACT, 2'd0, 1'b0, 1'b1);  // j=7
    chk("R9 activate at end of recovery", 1'b0, 4'd7);
  endtask

  task automatic testBurstStop();
    doReset();
    issue(C_ACT, 2'd0, 1'b0, 1'b1);
    issue(C_ACT, 2'd1, 1'b0, 1'b1);
    issue(C_WR, 2'd0, 1'b1, 1'b1);
    issue(C_BST, 2'd0, 1'b0, 1'b1);
    chk("R10 burst stop accepted", 1'b0, 4'd0);
    issue(C_RD, 2'd1, 1'b0, 1'b1);
    chk("R10 read after burst stop", 1'b0, 4'd0);
  endtask

  task automatic testNopAndCke();
    doReset();
    issue(4'b1011 & 4'b1011, 2'd3, 1'b0, 1'b1);
    issue({1'b1, 3'b011}, 2'd3, 1'b0, 1'b1);
    chk("R11 deselect with activate pattern", 1'b0, 4'd0);
    issue(C_ACT, 2'd3, 1'b0, 1'b1);
    chk("R11 bank untouched by deselect", 1'b0, 4'd0);
    doReset();
    issue(C_NOP, 2'd0, 1'b0, 1'b0);
    issue(C_ACT, 2'd2, 1'b0, 1'b1);
    chk("R12 command after low CKE", 1'b0, 4'd0);
    issue(C_ACT, 2'd2, 1'b0, 1'b1);
    chk("R12 ignored activate left bank closed", 1'b0, 4'd0);
    issue(C_ACT, 2'd2, 1'b0, 1'b1);
    chk("R5 R13 bank now open", 1'b1, 4'd5);
    issue(C_NOP, 2'd0, 1'b0, 1'b1);
    chk("R13 pulse lasts one cycle", 1'b0, 4'd5);
  endtask

  initial begin
    testReset();
    testBankRules();
    testPrecharge();
    testIdleRules();
    testMrsGap();
    testAutoPrecharge();
    testBurstStop();
    testNopAndCke();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule